// File: doc/BRIEF.md
# Chip-Select E-Clock Stretch Controller

This block lengthens external bus cycles so that slow peripherals have time to respond. Each of four chip selects has a 2-bit stretch count from zero to three. When an access falls in the range of a select whose count is nonzero, the external E-clock is held high for that many extra full E periods. A bus-hold output freezes address, data and control in the state they have at the end of E-high time. The internal clock and the internal E-phase pulses keep running throughout, so timers and baud generators are not affected.

An address decoder supplies a one-hot match vector, and a timing generator supplies one-cycle pulses that mark the normal start and the normal end of E-high time. The count for the matched select is loaded when the access starts. The count then drops by one at each normal E-fall point. E is released at the first fall point that finds the count at zero.

Top module: `estr_top`

## Requirements
- R1: After a synchronous reset, `e_clk`, `bus_hold` and `busy` are all low.
- R2: The stretch field layout is fixed. Bits [7:6] belong to I/O select 1 (`cs_hit[3]`), bits [5:4] to I/O select 2 (`cs_hit[2]`), bits [3:2] to the general-purpose select (`cs_hit[1]`) and bits [1:0] to the program select (`cs_hit[0]`). The higher bit of each pair is the MSB of the count.
- R3: When no stretch is pending or active, an `e_rise` pulse raises `e_clk` on the following cycle.
- R4: If no select matches, or the matching field is 0, `e_clk` falls the cycle after the first `e_fall` pulse. In that case neither `bus_hold` nor `busy` is ever raised.
- R5: With a matching field of N > 0, `e_clk` stays high through N `e_fall` pulses and falls the cycle after the (N+1)-th.
- R6: `bus_hold` rises the cycle after the first `e_fall` of a stretched access and falls together with `e_clk`. `e_clk` is high whenever `bus_hold` is high.
- R7: With N > 0, `busy` is high from the cycle after the access start until `e_clk` is released.
- R8: During a stretch, `e_rise` pulses and any `cs_hit` or configuration values present with them are ignored. The stretch length does not change.
- R9: `e_clk` changes only on the cycle after an `e_rise` or `e_fall` pulse.
- R10: Only the field of the matched select counts. The values in the other fields have no effect.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, never stretched |
| rst_n | input | 1 | Synchronous active-low reset |
| stretch_cfg | input | 8 | Four 2-bit stretch fields |
| cs_hit | input | 4 | One-hot (or zero) select-match vector from the decoder |
| e_rise | input | 1 | One-cycle pulse at the normal start of E-high time (access start) |
| e_fall | input | 1 | One-cycle pulse at the normal end of E-high time |
| e_clk | output | 1 | External E-clock |
| bus_hold | output | 1 | Freeze request for address, data and control |
| busy | output | 1 | Stretch pending or active |

## Verification
Accesses are tried in four ways:
- With no match at all, which shows that an idle decoder adds no delay.
- With a match on a select whose own field is zero while the other fields are three, which separates per-select stretching from any-field stretching.
- With each select in turn at the maximum count, which exposes a wrong field position or bit order.
- With random fields and matches mixed with random extra `e_rise` pulses inside a stretch, which shows whether a mid-stretch access start could reload or cut short the count.

// File: rtl/estr_pkg.sv
// Package: shared constants for the E-clock stretch controller.
// Assumes four selects with 2-bit fields by default; select indices give
// the match-bit position and the field position (field k = cfg[2k+1:2k]).
package estr_pkg;
    localparam int unsigned NSEL_DEF = 4;
    localparam int unsigned FW_DEF   = 2;

    typedef enum logic [1:0] {
        SEL_PROG = 2'd0,
        SEL_GEN  = 2'd1,
        SEL_IO2  = 2'd2,
        SEL_IO1  = 2'd3
    } sel_idx_e;
endpackage

// File: rtl/estr_field_sel.sv
// Module: picks the stretch field of the matched select.
// Assumes hit is one-hot or zero; with no hit the result is zero.
module estr_field_sel #(
    parameter int unsigned NSEL = 4,
    parameter int unsigned FW   = 2,
    localparam int unsigned CW  = NSEL * FW
) (
    input  logic [CW-1:0]   cfg,
    input  logic [NSEL-1:0] hit,
    output logic [FW-1:0]   field
);
    logic [FW-1:0] masked [NSEL];

    // Gate each field by its match bit.
    for (genvar s = 0; s < NSEL; s++) begin : g_mask
        assign masked[s] = hit[s] ? cfg[s*FW +: FW] : '0;
    end

    // OR the gated fields together into one count.
    always_comb begin
        field = '0;
        for (int s = 0; s < NSEL; s++) begin
            field = field | masked[s];
        end
    end
endmodule

// File: rtl/estr_counter.sv
// Module: stretch period counter and bus-hold flag.
// Loads the count on access start, then takes one off at each normal
// E-fall point. Assumes load and fall never pulse in the same cycle.
module estr_counter #(
    parameter int unsigned FW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_val,
    input  logic          fall,
    output logic          cnt_nz,
    output logic          hold
);
    logic [FW-1:0] cnt_q;
    logic          hold_q;

    assign cnt_nz = (cnt_q != '0);
    assign hold   = hold_q;

    // Count register: load at start, decrement at each fall while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (fall && cnt_nz) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Hold flag: set on a fall with periods left, cleared on the releasing fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (fall) begin
            hold_q <= cnt_nz;
        end
    end
endmodule

// File: rtl/estr_eclk.sv
// Module: external E-clock output register.
// Raises E at an accepted access start and lowers it at a fall point
// that has no stretch period left.
module estr_eclk (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fall,
    input  logic keep_high,
    output logic e_out
);
    logic e_q;

    assign e_out = e_q;

    // E register: set on start, cleared on an unstretched fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= 1'b0;
        end else if (start) begin
            e_q <= 1'b1;
        end else if (fall && !keep_high) begin
            e_q <= 1'b0;
        end
    end
endmodule

// File: rtl/estr_top.sv
// Module: chip-select E-clock stretch controller (top).
// Holds the external E high for 0..3 extra E periods when the current
// access matches a select with a nonzero stretch field. Timing pulses
// come from the free-running internal E generator, which is never stretched.
module estr_top #(
    parameter int unsigned NSEL = estr_pkg::NSEL_DEF,
    parameter int unsigned FW   = estr_pkg::FW_DEF,
    localparam int unsigned CW  = NSEL * FW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   stretch_cfg,
    input  logic [NSEL-1:0] cs_hit,
    input  logic            e_rise,
    input  logic            e_fall,
    output logic            e_clk,
    output logic            bus_hold,
    output logic            busy
);
    logic [FW-1:0] sel_field;
    logic          cnt_nz;
    logic          hold;
    logic          start;

    // An access start is accepted only when no stretch is pending or active.
    assign busy  = hold | cnt_nz;
    assign start = e_rise & ~busy;

    estr_field_sel #(.NSEL(NSEL), .FW(FW)) u_sel (
        .cfg   (stretch_cfg),
        .hit   (cs_hit),
        .field (sel_field)
    );

    estr_counter #(.FW(FW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (sel_field),
        .fall     (e_fall),
        .cnt_nz   (cnt_nz),
        .hold     (hold)
    );

    estr_eclk u_e (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fall      (e_fall),
        .keep_high (cnt_nz),
        .e_out     (e_clk)
    );

    assign bus_hold = hold;
endmodule

// File: rtl/estr_checker.sv
// Module: property checker for estr_top, attached by bind.
// Computes the matched field on its own from the ports.
module estr_checker #(
    parameter int unsigned NSEL = 4,
    parameter int unsigned FW   = 2,
    localparam int unsigned CW  = NSEL * FW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CW-1:0]   stretch_cfg,
    input logic [NSEL-1:0] cs_hit,
    input logic            e_rise,
    input logic            e_fall,
    input logic            e_clk,
    input logic            bus_hold,
    input logic            busy
);
    logic [FW-1:0] ref_field;

    // Reference field lookup by scanning match bits.
    always_comb begin
        ref_field = '0;
        for (int s = 0; s < NSEL; s++) begin
            if (cs_hit[s]) ref_field = stretch_cfg[s*FW +: FW];
        end
    end

    AST_HOLD_E_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> e_clk); // R6
    AST_HOLD_STARTS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hold) |-> $past(e_fall)); // R6
    AST_E_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_clk) |-> $past(e_fall)); // R9
    AST_E_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_clk) |-> $past(e_rise)); // R9
    AST_NO_FIELD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise && !busy && ref_field == '0) |=> !busy); // R4
    AST_START_RAISES_E: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise && !busy) |=> e_clk); // R3
    AST_RISE_IGNORED_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hold && e_rise) |=> (bus_hold && e_clk)); // R8
endmodule

bind estr_top estr_checker #(.NSEL(NSEL), .FW(FW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stretch_cfg (stretch_cfg),
    .cs_hit      (cs_hit),
    .e_rise      (e_rise),
    .e_fall      (e_fall),
    .e_clk       (e_clk),
    .bus_hold    (bus_hold),
    .busy        (busy)
);

// File: tb/sim_estr_top.sv
// Bench: directed corner cases plus seeded random accesses for estr_top.
module sim_estr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stretch_cfg = '0;
    logic [3:0] cs_hit = '0;
    logic       e_rise = 1'b0;
    logic       e_fall = 1'b0;
    logic       e_clk, bus_hold, busy;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #5 clk = ~clk;

    estr_top u0 (
        .clk(clk), .rst_n(rst_n), .stretch_cfg(stretch_cfg), .cs_hit(cs_hit),
        .e_rise(e_rise), .e_fall(e_fall), .e_clk(e_clk), .bus_hold(bus_hold),
        .busy(busy)
    );

    // Expected count for a match vector (R2 layout: field k = cfg[2k+1:2k]).
    function automatic int exp_count(logic [7:0] cfg, logic [3:0] hit);
        int r = 0;
        for (int k = 0; k < 4; k++) if (hit[k]) r = int'(cfg[2*k +: 2]);
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One access: start, then fall points until release, with checks.
    task automatic access(logic [7:0] cfg, logic [3:0] hit, bit noisy, string req);
        int n = exp_count(cfg, hit);
        stretch_cfg = cfg; cs_hit = hit; e_rise = 1'b1;
        @(negedge clk); e_rise = 1'b0; cs_hit = '0;
        check(e_clk == 1'b1, "R3", e_clk, 1);
        check(busy == (n != 0), "R7", busy, n != 0);
        check(bus_hold == 1'b0, req, bus_hold, 0);
        idle(2);
        check(e_clk == 1'b1, "R9", e_clk, 1);
        for (int k = 0; k <= n; k++) begin
            e_fall = 1'b1;
            @(negedge clk); e_fall = 1'b0;
            if (k < n) begin
                check(e_clk == 1'b1, req, e_clk, 1);
                check(bus_hold == 1'b1, "R6", bus_hold, 1);
                idle(1);
                if (noisy) begin
                    // R8: new start mid-stretch with a changed config must be ignored
                    stretch_cfg = 8'hFF; cs_hit = 4'b0001; e_rise = 1'b1;
                    @(negedge clk); e_rise = 1'b0; cs_hit = '0; stretch_cfg = cfg;
                    check(bus_hold == 1'b1 && e_clk == 1'b1, "R8", bus_hold, 1);
                end
                idle(1);
            end else begin
                check(e_clk == 1'b0, (n == 0) ? "R4" : "R5", e_clk, 0);
                check(bus_hold == 1'b0, "R6", bus_hold, 0);
                check(busy == 1'b0, "R7", busy, 0);
            end
        end
        idle(2);
        check(e_clk == 1'b0, "R9", e_clk, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        check(e_clk == 0 && bus_hold == 0 && busy == 0, "R1", e_clk + bus_hold + busy, 0);
        rst_n = 1'b1;
        idle(1);
        check(e_clk == 0 && bus_hold == 0 && busy == 0, "R1", e_clk + bus_hold + busy, 0);

        access(8'hFF, 4'b0000, 1'b0, "R4");      // no match, all fields max
        access(8'h00, 4'b0100, 1'b0, "R4");      // match, field zero
        access(8'hF3, 4'b0010, 1'b0, "R10");     // general field 0, others 3
        access(8'hC0, 4'b1000, 1'b0, "R2");      // I/O 1 at 3
        access(8'h30, 4'b0100, 1'b0, "R2");      // I/O 2 at 3
        access(8'h0C, 4'b0010, 1'b0, "R2");      // general at 3
        access(8'h03, 4'b0001, 1'b0, "R2");      // program at 3
        access(8'h80, 4'b1000, 1'b1, "R2");      // MSB of I/O 1 -> 2
        access(8'h01, 4'b0001, 1'b1, "R5");      // 1 period, noisy
        access(8'h3C, 4'b1001, 1'b0, "R10");     // unused fields set, match zero fields

        for (int t = 0; t < 300; t++) begin
            logic [7:0] cfg = 8'($urandom);
            int         s   = int'($urandom_range(0, 4));
            logic [3:0] hit = (s == 4) ? 4'b0000 : 4'(1 << s);
            access(cfg, hit, 1'($urandom), "R5");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule